// File: doc/BRIEF.md
# Video Window Cropper with Decimation

This block sits on a parallel camera pixel stream and forwards only a chosen part of each image. Incoming pixels are qualified by three strobes: frame-valid, line-valid and data-valid. A pixel is counted only on a clock edge where all three are high. Because of this, a slow camera that drops data-valid between pixels is handled with no extra logic. The block keeps a column and a row position for every counted pixel. It decides from those positions whether the pixel lies inside the window. It then thins the surviving pixels by a power-of-two factor on each axis.

There are three cropping modes:
- **Rectangle mode** keeps a box given by an x offset, y offset, width and height.
- **Line-sensor mode** crops each line by x offset and width only. The height setting instead cuts the incoming lines into groups, and each group is reported downstream as a frame of its own.
- **Pass-all mode** keeps every pixel seen while frame-valid and line-valid are high, so lines of any length go through unchanged.

The output carries each kept pixel with four marker bits: first of frame, last of frame, first of line, last of line. The end of a line or frame is only known once the strobes fall. For that reason one kept pixel is always held back. It is released when the next kept pixel arrives or when its frame or group closes. A camera cannot be stalled, so the output is a valid-only stream with no back-pressure. The consumer must take every beat in the cycle it appears.

Top module: `roi_subsampler`

## Requirements
- R1: Mode code 0 (rectangle) keeps pixel (col,row) only when x_off <= col < x_off+width and y_off <= row < y_off+height. Columns count from 0 at each line start and rows count from 0 at each frame start.
- R2: Mode code 1 (line sensor) crops columns as in R1 and ignores y_off. Each run of `height` consecutive lines inside frame-valid forms one output frame, with its own first-of-frame and last-of-frame beats. The row position restarts at 0 in each run.
- R3: Mode code 2 (pass all) keeps every counted pixel, whatever the length of each line.
- R4: Horizontal decimation code 0, 1, 2 or 3 keeps every 1st, 2nd, 4th or 8th pixel. The count is taken from the first column of the window: column x_off in modes 0 and 1, and column 0 in mode 2.
- R5: Vertical decimation code 0, 1, 2 or 3 keeps every 1st, 2nd, 4th or 8th line. The count is taken from the first row of the window: y_off in mode 0, the first line of each group in mode 1, and row 0 in mode 2.
- R6: A cycle with data-valid low neither produces a beat nor advances the column position.
- R7: Marker bits are set as follows. out_sof is set on the first kept beat of every frame or group, and out_eof on its last. out_sol is set on the first kept beat of each line, and out_eol on its last. Every out_sof beat also has out_sol, and every out_eof beat also has out_eol.
- R8: Window, mode and decimation settings are taken at the rising edge of frame-valid. Changes made while frame-valid stays high do not affect the frame in progress.
- R9: The output keeps the input pixel order and applies no back-pressure. During and after reset, with no frame input, out_valid stays low.
- R10: A width or height of 0 in mode 0 produces no beats for the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_mode | input | 2 | 0 rectangle, 1 line sensor, 2 pass all, 3 behaves as 0 |
| cfg_x_off | input | CW | First column of the window |
| cfg_y_off | input | RW | First row of the window (mode 0) |
| cfg_width | input | CW | Window width in columns |
| cfg_height | input | RW | Window height (mode 0) or lines per group (mode 1) |
| cfg_x_decim | input | 2 | Horizontal decimation code |
| cfg_y_decim | input | 2 | Vertical decimation code |
| cam_fval | input | 1 | Frame-valid strobe |
| cam_lval | input | 1 | Line-valid strobe |
| cam_dval | input | 1 | Data-valid strobe |
| cam_data | input | DW | Pixel value |
| out_valid | output | 1 | A kept pixel is present this cycle |
| out_data | output | DW | Kept pixel value |
| out_sof | output | 1 | First beat of frame or group |
| out_eof | output | 1 | Last beat of frame or group |
| out_sol | output | 1 | First beat of line |
| out_eol | output | 1 | Last beat of line |

## Verification
The hardest case to reach is a line-sensor group whose last line is removed by vertical decimation. The last-of-frame marker must then land on a pixel from an earlier line, and only when the skipped line ends. The bench reaches it with a group of four lines and a vertical factor of 2, so the closing line of each group is one that is dropped. The second group is cut short by the falling frame-valid.

A second hard case is a settings change in the middle of a frame. The bench rewrites every window setting partway through a frame. It checks that the current frame still follows the old window and that the next frame follows the new one.

// File: rtl/roi_pkg.sv
package roi_pkg;
  typedef enum logic [1:0] {
    MODE_AREA   = 2'd0,
    MODE_LINE   = 2'd1,
    MODE_STREAM = 2'd2,
    MODE_RSVD   = 2'd3
  } roi_mode_e;

  // Decimation code to low-bit phase mask (x1, x2, x4, x8)
  function automatic logic [2:0] decim_mask(input logic [1:0] code);
    case (code)
      2'd0:    decim_mask = 3'b000;
      2'd1:    decim_mask = 3'b001;
      2'd2:    decim_mask = 3'b011;
      default: decim_mask = 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/roi_pos_track.sv
module roi_pos_track #(
  parameter int CW = 12,
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fval,
  input  logic          lval,
  input  logic          dval,
  input  logic          line_mode,
  input  logic [RW-1:0] height,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic          frame_rise,
  output logic          group_start,
  output logic          group_end,
  output logic          line_start,
  output logic          line_end
);
  logic fval_q, lval_q, lval_fall, wrap;
  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;

  assign frame_rise  = fval & ~fval_q;
  assign lval_fall   = ~lval & lval_q;
  assign wrap        = line_mode & fval & lval_fall & (row_q == height - 1'b1);
  assign group_start = frame_rise | wrap;
  assign group_end   = (~fval & fval_q) | wrap;
  assign line_start  = fval & lval & (~lval_q | ~fval_q);
  assign line_end    = lval_fall;
  assign col         = col_q;
  assign row         = row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fval_q <= 1'b0;
      lval_q <= 1'b0;
      col_q  <= '0;
      row_q  <= '0;
    end else begin
      fval_q <= fval;
      lval_q <= lval;
      if (!lval)               col_q <= '0;
      else if (dval && fval)   col_q <= col_q + 1'b1;
      if (!fval)               row_q <= '0;
      else if (lval_fall)      row_q <= wrap ? '0 : row_q + 1'b1;
    end
  end

  // Row position never leaves its group in line-sensor mode
  p_row_in_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_mode && fval && fval_q && height != '0) |-> (row_q < height));
endmodule

// File: rtl/roi_cfg_hold.sv
module roi_cfg_hold import roi_pkg::*; #(
  parameter int CW = 12,
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  roi_mode_e     in_mode,
  input  logic [CW-1:0] in_x_off,
  input  logic [RW-1:0] in_y_off,
  input  logic [CW-1:0] in_width,
  input  logic [RW-1:0] in_height,
  input  logic [1:0]    in_x_dec,
  input  logic [1:0]    in_y_dec,
  output roi_mode_e     mode,
  output logic [CW-1:0] x_off,
  output logic [RW-1:0] y_off,
  output logic [CW-1:0] width,
  output logic [RW-1:0] height,
  output logic [1:0]    x_dec,
  output logic [1:0]    y_dec
);
  roi_mode_e     sh_mode;
  logic [CW-1:0] sh_x_off, sh_width;
  logic [RW-1:0] sh_y_off, sh_height;
  logic [1:0]    sh_x_dec, sh_y_dec;

  // The frame-start cycle already uses the new settings
  assign mode   = take ? in_mode   : sh_mode;
  assign x_off  = take ? in_x_off  : sh_x_off;
  assign y_off  = take ? in_y_off  : sh_y_off;
  assign width  = take ? in_width  : sh_width;
  assign height = take ? in_height : sh_height;
  assign x_dec  = take ? in_x_dec  : sh_x_dec;
  assign y_dec  = take ? in_y_dec  : sh_y_dec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_mode   <= MODE_AREA;
      sh_x_off  <= '0;
      sh_y_off  <= '0;
      sh_width  <= '0;
      sh_height <= '0;
      sh_x_dec  <= '0;
      sh_y_dec  <= '0;
    end else if (take) begin
      sh_mode   <= in_mode;
      sh_x_off  <= in_x_off;
      sh_y_off  <= in_y_off;
      sh_width  <= in_width;
      sh_height <= in_height;
      sh_x_dec  <= in_x_dec;
      sh_y_dec  <= in_y_dec;
    end
  end
endmodule

// File: rtl/roi_window.sv
module roi_window import roi_pkg::*; #(
  parameter int CW = 12,
  parameter int RW = 12
) (
  input  roi_mode_e     mode,
  input  logic [CW-1:0] x_off,
  input  logic [RW-1:0] y_off,
  input  logic [CW-1:0] width,
  input  logic [RW-1:0] height,
  input  logic [1:0]    x_dec,
  input  logic [1:0]    y_dec,
  input  logic [CW-1:0] col,
  input  logic [RW-1:0] row,
  output logic          keep
);
  logic [CW:0] x_end;
  logic [RW:0] y_end;
  logic        in_x, in_y;
  logic [2:0]  x_ph, y_ph;

  assign x_end = {1'b0, x_off} + {1'b0, width};
  assign y_end = {1'b0, y_off} + {1'b0, height};

  always_comb begin
    in_x = 1'b1;
    in_y = 1'b1;
    x_ph = col[2:0];
    y_ph = row[2:0];
    case (mode)
      MODE_STREAM: ;
      MODE_LINE: begin
        in_x = (col >= x_off) && ({1'b0, col} < x_end);
        x_ph = col[2:0] - x_off[2:0];
      end
      default: begin
        in_x = (col >= x_off) && ({1'b0, col} < x_end);
        in_y = (row >= y_off) && ({1'b0, row} < y_end);
        x_ph = col[2:0] - x_off[2:0];
        y_ph = row[2:0] - y_off[2:0];
      end
    endcase
    keep = in_x && in_y
        && ((x_ph & decim_mask(x_dec)) == 3'b000)
        && ((y_ph & decim_mask(y_dec)) == 3'b000);
  end
endmodule

// File: rtl/roi_emit.sv
module roi_emit #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [DW-1:0] pix,
  input  logic          group_start,
  input  logic          group_end,
  input  logic          line_start,
  input  logic          line_end,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eof,
  output logic          out_sol,
  output logic          out_eol
);
  logic          sof_pend, sol_pend, sof_now, sol_now;
  logic          h_v, h_sof, h_sol, h_eol;
  logic [DW-1:0] h_d;

  assign sof_now = sof_pend | group_start;
  assign sol_now = sol_pend | line_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sof_pend  <= 1'b1;
      sol_pend  <= 1'b1;
      h_v       <= 1'b0;
      h_d       <= '0;
      h_sof     <= 1'b0;
      h_sol     <= 1'b0;
      h_eol     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_sol   <= 1'b0;
      out_eol   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_sol   <= 1'b0;
      out_eol   <= 1'b0;
      sof_pend  <= sof_now & ~accept;
      sol_pend  <= sol_now & ~accept;
      if (accept) begin
        if (h_v) begin
          out_valid <= 1'b1;
          out_data  <= h_d;
          out_sof   <= h_sof;
          out_sol   <= h_sol;
          out_eol   <= h_eol;
        end
        h_v   <= 1'b1;
        h_d   <= pix;
        h_sof <= sof_now;
        h_sol <= sol_now;
        h_eol <= 1'b0;
      end else if (group_end) begin
        if (h_v) begin
          out_valid <= 1'b1;
          out_data  <= h_d;
          out_sof   <= h_sof;
          out_sol   <= h_sol;
          out_eol   <= 1'b1;
          out_eof   <= 1'b1;
        end
        h_v <= 1'b0;
      end else if (line_end) begin
        h_eol <= 1'b1;
      end
    end
  end

  // Marker sequencing watchers
  logic exp_sol_q, exp_sof_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_sol_q <= 1'b1;
      exp_sof_q <= 1'b1;
    end else if (out_valid) begin
      exp_sol_q <= out_eol;
      exp_sof_q <= out_eof;
    end
  end

  p_eof_has_eol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eof) |-> out_eol);
  p_sof_has_sol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> out_sol);
  p_line_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exp_sol_q) |-> out_sol);
  p_frame_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exp_sof_q) |-> out_sof);
  p_markers_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(out_sof || out_eof || out_sol || out_eol));
endmodule

// File: rtl/roi_subsampler.sv
module roi_subsampler import roi_pkg::*; #(
  parameter int DW = 16,
  parameter int CW = 12,
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_mode,
  input  logic [CW-1:0] cfg_x_off,
  input  logic [RW-1:0] cfg_y_off,
  input  logic [CW-1:0] cfg_width,
  input  logic [RW-1:0] cfg_height,
  input  logic [1:0]    cfg_x_decim,
  input  logic [1:0]    cfg_y_decim,
  input  logic          cam_fval,
  input  logic          cam_lval,
  input  logic          cam_dval,
  input  logic [DW-1:0] cam_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eof,
  output logic          out_sol,
  output logic          out_eol
);
  roi_mode_e     e_mode;
  logic [CW-1:0] e_x_off, e_width, col;
  logic [RW-1:0] e_y_off, e_height, row;
  logic [1:0]    e_x_dec, e_y_dec;
  logic          frame_rise, group_start, group_end, line_start, line_end;
  logic          keep, accept;

  roi_pos_track #(.CW(CW), .RW(RW)) u_track (
    .clk(clk), .rst_n(rst_n),
    .fval(cam_fval), .lval(cam_lval), .dval(cam_dval),
    .line_mode(e_mode == MODE_LINE), .height(e_height),
    .col(col), .row(row),
    .frame_rise(frame_rise), .group_start(group_start), .group_end(group_end),
    .line_start(line_start), .line_end(line_end)
  );

  roi_cfg_hold #(.CW(CW), .RW(RW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .take(frame_rise),
    .in_mode(roi_mode_e'(cfg_mode)), .in_x_off(cfg_x_off), .in_y_off(cfg_y_off),
    .in_width(cfg_width), .in_height(cfg_height),
    .in_x_dec(cfg_x_decim), .in_y_dec(cfg_y_decim),
    .mode(e_mode), .x_off(e_x_off), .y_off(e_y_off),
    .width(e_width), .height(e_height), .x_dec(e_x_dec), .y_dec(e_y_dec)
  );

  roi_window #(.CW(CW), .RW(RW)) u_win (
    .mode(e_mode), .x_off(e_x_off), .y_off(e_y_off),
    .width(e_width), .height(e_height), .x_dec(e_x_dec), .y_dec(e_y_dec),
    .col(col), .row(row), .keep(keep)
  );

  assign accept = cam_fval & cam_lval & cam_dval & keep;

  roi_emit #(.DW(DW)) u_emit (
    .clk(clk), .rst_n(rst_n), .accept(accept), .pix(cam_data),
    .group_start(group_start), .group_end(group_end),
    .line_start(line_start), .line_end(line_end),
    .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_sol(out_sol), .out_eol(out_eol)
  );

  // A cycle without data-valid never becomes a kept pixel
  p_no_beat_without_dval_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cam_fval && cam_lval && !cam_dval) |=> !(u_emit.h_v && !$past(u_emit.h_v)));
endmodule

// File: tb/roi_subsampler_bench.sv
`timescale 1ns/1ps
module roi_subsampler_bench;
  localparam int DW = 16, CW = 12, RW = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [1:0]    cfg_mode, cfg_x_decim, cfg_y_decim;
  logic [CW-1:0] cfg_x_off, cfg_width;
  logic [RW-1:0] cfg_y_off, cfg_height;
  logic          cam_fval, cam_lval, cam_dval;
  logic [DW-1:0] cam_data;
  logic          out_valid, out_sof, out_eof, out_sol, out_eol;
  logic [DW-1:0] out_data;

  roi_subsampler #(.DW(DW), .CW(CW), .RW(RW)) u_roi_subsampler (
    .clk(clk), .rst_n(rst_n),
    .cfg_mode(cfg_mode), .cfg_x_off(cfg_x_off), .cfg_y_off(cfg_y_off),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_x_decim(cfg_x_decim), .cfg_y_decim(cfg_y_decim),
    .cam_fval(cam_fval), .cam_lval(cam_lval), .cam_dval(cam_dval), .cam_data(cam_data),
    .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_sol(out_sol), .out_eol(out_eol)
  );

  int checks = 0, errors = 0;

  // Columns: mode, xoff, yoff, width, height, xdec, ydec, cols, rows, varlen, gaps, expected beats
  localparam int VEC [10][12] = '{
    '{0, 2, 1, 4, 3, 0, 0,  8, 5, 0, 0, 12},  // R1 plain rectangle
    '{0, 1, 1, 5, 5, 1, 1,  8, 7, 0, 0,  9},  // R4 R5 x2 both axes inside offset window
    '{0, 0, 0, 8, 2, 2, 0, 10, 3, 0, 1,  4},  // R4 x4, R6 data-valid gaps
    '{0, 0, 0,10, 6, 3, 2, 12, 8, 0, 0,  4},  // R4 x8, R5 x4
    '{1, 1, 0, 3, 2, 0, 0,  6, 5, 0, 0, 15},  // R2 groups of 2 lines, last group short
    '{1, 0, 0, 4, 4, 0, 1,  5, 6, 0, 0, 12},  // R2 R5 group closes on a dropped line
    '{2, 0, 0, 0, 0, 0, 0,  4, 4, 1, 0, 19},  // R3 varying line lengths
    '{2, 0, 0, 0, 0, 1, 1,  5, 5, 1, 1, 10},  // R3 R4 R5 R6 decimated, gaps
    '{0, 0, 0, 0, 3, 0, 0,  4, 4, 0, 0,  0},  // R10 zero width
    '{0, 6, 3, 5, 5, 0, 0,  8, 5, 0, 0,  4}   // R1 window overhangs frame edge
  };

  // Collected beats
  logic [DW-1:0] got_d [0:2047];
  logic [3:0]    got_m [0:2047];
  int            ng = 0;
  // Model beats
  logic [DW-1:0] exp_d [0:2047];
  logic [3:0]    exp_m [0:2047];
  int            exp_r [0:2047];
  int            exp_g [0:2047];
  int            ne = 0;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1 && ng < 2048) begin
      got_d[ng] = out_data;
      got_m[ng] = {out_sof, out_eof, out_sol, out_eol};
      ng++;
    end
  end

  function automatic string tag_of(input int md);
    if (md == 1) return "R2";
    if (md == 2) return "R3";
    return "R1";
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int md, xo, yo, w, h, dx, dy);
    cfg_mode = 2'(md); cfg_x_off = CW'(xo); cfg_y_off = RW'(yo);
    cfg_width = CW'(w); cfg_height = RW'(h);
    cfg_x_decim = 2'(dx); cfg_y_decim = 2'(dy);
  endtask

  // Independent model of the kept pixels and their markers
  task automatic build_exp(input int md, xo, yo, w, h, dx, dy, cols, rows, vr);
    int mx, my;
    mx = (1 << dx) - 1;
    my = (1 << dy) - 1;
    ne = 0;
    for (int r = 0; r < rows; r++) begin
      int len, g, rr;
      bit ky;
      len = cols + (vr != 0 ? r % 3 : 0);
      g = 0; rr = r;
      if (md == 1) begin g = r / h; rr = r % h; ky = ((rr & my) == 0); end
      else if (md == 2) ky = ((r & my) == 0);
      else ky = (r >= yo) && (r < yo + h) && (((r - yo) & my) == 0);
      for (int c = 0; c < len; c++) begin
        bit kx;
        if (md == 2) kx = ((c & mx) == 0);
        else kx = (c >= xo) && (c < xo + w) && (((c - xo) & mx) == 0);
        if (kx && ky) begin
          exp_d[ne] = {8'(r), 8'(c)};
          exp_r[ne] = r;
          exp_g[ne] = g;
          ne++;
        end
      end
    end
    for (int i = 0; i < ne; i++) begin
      bit sof, eof, sol, eol;
      sof = (i == 0);
      if (i > 0) sof = (exp_g[i] != exp_g[i-1]);
      eof = (i == ne - 1);
      if (i < ne - 1) eof = (exp_g[i+1] != exp_g[i]);
      sol = sof;
      if (i > 0) sol = sof || (exp_r[i] != exp_r[i-1]);
      eol = eof;
      if (i < ne - 1) eol = eof || (exp_r[i+1] != exp_r[i]);
      exp_m[i] = {sof, eof, sol, eol};
    end
  endtask

  // poke: rewrite all settings at the start of line 1 (R8)
  task automatic run_frame(input int cols, rows, vr, gp, poke);
    ng = 0;
    cam_fval = 1'b1; cam_lval = 1'b0; cam_dval = 1'b0;
    repeat (2) @(negedge clk);
    for (int r = 0; r < rows; r++) begin
      int len;
      len = cols + (vr != 0 ? r % 3 : 0);
      for (int c = 0; c < len; c++) begin
        if (poke != 0 && r == 1 && c == 0) set_cfg(0, 0, 1, 1, 3, 0, 0);
        if (gp != 0 && (c % 2) == 1) begin
          cam_lval = 1'b1; cam_dval = 1'b0; cam_data = 16'hDEAD;
          @(negedge clk);
        end
        cam_lval = 1'b1; cam_dval = 1'b1; cam_data = {8'(r), 8'(c)};
        @(negedge clk);
      end
      cam_lval = 1'b0; cam_dval = 1'b0;
      repeat (2) @(negedge clk);
    end
    cam_fval = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic compare(input string req, input int exp_cnt);
    int bad;
    check(ng == exp_cnt, req, "beat count", ng, exp_cnt);
    bad = -1;
    for (int i = 0; i < ng && i < ne; i++)
      if (bad < 0 && (got_d[i] !== exp_d[i] || got_m[i] !== exp_m[i])) bad = i;
    if (bad < 0 && ng != ne) bad = (ng < ne) ? ng : ne;
    if (bad >= 0 && bad < ng && bad < ne)
      check(0, {req, "/R7"}, $sformatf("beat %0d data/markers(sof,eof,sol,eol)", bad),
            int'({got_m[bad], got_d[bad]}), int'({exp_m[bad], exp_d[bad]}));
    else
      check(bad < 0, {req, "/R7"}, "beat sequence length vs model", ng, ne);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cam_fval = 1'b0; cam_lval = 1'b0; cam_dval = 1'b0; cam_data = '0;
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid === 1'b0 && ng == 0, "R9", "beats after reset with idle inputs", ng, 0);

    for (int v = 0; v < 10; v++) begin
      set_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]);
      build_exp(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6],
                VEC[v][7], VEC[v][8], VEC[v][9]);
      run_frame(VEC[v][7], VEC[v][8], VEC[v][9], VEC[v][10], 0);
      compare(tag_of(VEC[v][0]), VEC[v][11]);
    end

    // R8: settings rewritten mid-frame apply only from the next frame
    set_cfg(0, 2, 1, 4, 3, 0, 0);
    build_exp(0, 2, 1, 4, 3, 0, 0, 8, 5, 0);
    run_frame(8, 5, 0, 0, 1);
    compare("R8", 12);
    build_exp(0, 0, 1, 1, 3, 0, 0, 8, 5, 0);
    run_frame(8, 5, 0, 0, 0);
    compare("R8", 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule